// File: doc/BRIEF.md
# Bus Clock Band Detector and DPLL Tuning Sequencer

This block works out which of four frequency bands the reference bus clock falls into, then tunes a DPLL to a fixed target frequency. A `start` pulse begins a run. The block first needs a bus frequency value. It takes that value straight from a status word when the word carries a valid tag. Otherwise it averages a sampled 9-bit counter. The value is scaled by a base constant into an estimate in MHz, and the estimate is sorted into a band.

From the band and the chosen target (66 MHz or 50 MHz), the block computes a lower and an upper tuning limit and writes them into a 32-bit DPLL control word with the tuning enable set. It then polls the DPLL lock flag. A lock counts only when the flag stays set over a long run of consecutive samples. When an attempt fails, the block widens one limit, rewrites the word and tries again. The step grows with the attempt number, and the limit that moves alternates between upper and lower. The run ends with `done` and either `success` or `fail`. `done` and all results are held until the next `start`.

Top module: `clk_band_tuner`

## Requirements
- R1: After reset, `done`, `success` and `fail` are low, and `band`, `targetMhz` and `ctrlWord` are zero.
- R2: If bits 31:12 of `freqStatus` equal 0xABCDE, the frequency value is `freqStatus[8:0]`. Otherwise it is the sum of 2^AVG_LOG2 samples of `sampleCnt` (one sample every AVG_WAIT clocks) shifted right by AVG_LOG2, kept to 9 bits.
- R3: The estimate is floor(baseConst × frequency / 192). `band` is 0 below 40, 1 below 45, 2 below 55, and 3 otherwise. The band frequencies are 33, 40, 50 and 66 MHz.
- R4: `targetMhz` is 66 when `hiSpeedCap` is high and 50 when it is low.
- R5: The lower limit is floor(bandMHz × 48 / targetMhz). The upper limit is the lower limit plus 2, plus a further 2 when `band` is 2 or 3. The first word written is upper<<16 | lower | 0x100, where bit 8 is the tuning enable.
- R6: Once a poll sees `lockFlag` set, the flag is sampled on every clock. The attempt qualifies only if the flag reads set on HOLD_SAMPLES consecutive clocks. Any clear sample fails the attempt.
- R7: After failed attempt n (counting from 0), an odd n lowers the lower limit by n>>1 and an even n raises the upper limit by n>>1. The word is rewritten with bit 8 set before the next attempt.
- R8: A qualified lock clears bit 8 of `ctrlWord` and raises `success` and `done`.
- R9: When MAX_TRIES attempts have failed, `fail` and `done` rise. `ctrlWord` then holds the word rewritten after the last step, with bit 8 still set.
- R10: `done`, `band`, `targetMhz` and `ctrlWord` hold steady until the next `start`. A `start` while `done` is high clears `done`, `success` and `fail` on the next clock. A `start` during a run is ignored.
- R11: Within one attempt, `lockFlag` is polled once every POLL_WAIT clocks. The attempt fails after MAX_POLLS polls that all read clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run |
| freqStatus | input | 32 | Frequency status word: tag in bits 31:12, value in bits 8:0 |
| sampleCnt | input | 9 | Sampled counter, averaged when the tag is absent |
| baseConst | input | 8 | Base constant for the MHz estimate |
| hiSpeedCap | input | 1 | Selects the 66 MHz target; low selects 50 MHz |
| lockFlag | input | 1 | DPLL lock indication |
| band | output | 2 | Frequency band index |
| targetMhz | output | 7 | Chosen DPLL target in MHz |
| ctrlWord | output | 32 | DPLL control word |
| done | output | 1 | Run complete; held until the next start |
| success | output | 1 | The run ended with a qualified lock |
| fail | output | 1 | All attempts failed |

## Verification
Only one result has a fixed latency: `done`, `success` and `fail` fall one clock after a sampled `start`, and the bench samples them at the next falling edge. The end of a run depends on the serial divider and on how many polls the lock takes. So the bench waits for `done` and then compares `band`, `targetMhz`, `success` and `fail` with values computed from the requirements. It also checks over the following clocks that they stay unchanged. `ctrlWord` is recorded each time it changes and compared, in order, with the word schedule the bench predicts. The bench's DPLL model decides lock from the word alone. Its expected attempt count therefore does not depend on exact cycle counts.

// File: rtl/clk_band_tuner_pkg.sv
package clk_band_tuner_pkg;

  localparam int LIM_W = 16;
  localparam int WORD_W = 2 * LIM_W;
  localparam int ENABLE_BIT = 8;
  localparam logic [19:0] FREQ_TAG = 20'hABCDE;
  localparam int SCALE_DIV = 192;
  localparam int BAND1_MIN = 40;
  localparam int BAND2_MIN = 45;
  localparam int BAND3_MIN = 55;
  localparam int REF_MULT = 48;

  typedef struct packed {
    logic clrAcc;
    logic addSample;
    logic latchTag;
    logic latchAvg;
    logic divGo;
    logic divSel;
    logic loadBand;
    logic loadLimits;
    logic writeWord;
    logic stepLimits;
    logic dropEnable;
  } dpCmd_t;

  typedef enum logic [3:0] {
    S_IDLE, S_AVG, S_AVG_END, S_MHZ_GO, S_MHZ_RUN, S_LIM_GO, S_LIM_RUN,
    S_WRITE, S_POLL, S_HOLD, S_STEP, S_REWRITE
  } seqState_t;

  function automatic logic [6:0] bandToMhz(input logic [1:0] b);
    case (b)
      2'd0:    bandToMhz = 7'd33;
      2'd1:    bandToMhz = 7'd40;
      2'd2:    bandToMhz = 7'd50;
      default: bandToMhz = 7'd66;
    endcase
  endfunction

endpackage

// File: rtl/tuner_divider.sv
module tuner_divider #(
  parameter int NUM_W = 17,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic [NUM_W-1:0] quot,
  output logic             fin
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] dReg;
  logic [NUM_W-1:0] q;
  logic [CNT_W-1:0] left;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;

  assign trial = {rem, q[NUM_W-1]};
  assign diff  = trial - {1'b0, dReg};
  assign quot  = q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem  <= '0;
      dReg <= '0;
      q    <= '0;
      left <= '0;
      fin  <= 1'b0;
    end else if (go) begin
      q    <= numer;
      rem  <= '0;
      dReg <= denom;
      left <= CNT_W'(NUM_W);
      fin  <= 1'b0;
    end else if (left != '0) begin
      if (trial >= {1'b0, dReg}) begin
        rem <= diff[DEN_W-1:0];
        q   <= {q[NUM_W-2:0], 1'b1};
      end else begin
        rem <= trial[DEN_W-1:0];
        q   <= {q[NUM_W-2:0], 1'b0};
      end
      left <= left - 1'b1;
      fin  <= (left == CNT_W'(1));
    end else begin
      fin <= 1'b0;
    end
  end
endmodule

// File: rtl/tuner_datapath.sv
module tuner_datapath
  import clk_band_tuner_pkg::*;
#(
  parameter int BASE_W   = 8,
  parameter int CNT_W    = 9,
  parameter int AVG_LOG2 = 7,
  parameter int TRY_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [31:0]       freqStatus,
  input  logic [CNT_W-1:0]  sampleCnt,
  input  logic [BASE_W-1:0] baseConst,
  input  logic              hiSpeedCap,
  input  logic [TRY_W-1:0]  tryIdx,
  output logic              tagOk,
  output logic              divDone,
  output logic [1:0]        band,
  output logic [6:0]        targetMhz,
  output logic [WORD_W-1:0] ctrlWord
);
  localparam int NUM_W = BASE_W + CNT_W;
  localparam int DEN_W = 8;
  localparam int ACC_W = CNT_W + AVG_LOG2;

  logic [ACC_W-1:0] accSum;
  logic [CNT_W-1:0] freqReg;
  logic [NUM_W-1:0] divNum;
  logic [DEN_W-1:0] divDen;
  logic [NUM_W-1:0] divQuot;
  logic [1:0]       bandReg;
  logic [6:0]       targetReg;
  logic [LIM_W-1:0] lowLim;
  logic [LIM_W-1:0] highLim;
  logic [WORD_W-1:0] wordReg;
  logic [1:0]       bandNext;
  logic [LIM_W-1:0] stepAmt;
  logic [LIM_W-1:0] widenAmt;

  assign tagOk = (freqStatus[31:12] == FREQ_TAG);

  // Shared divider: estimate in MHz first, then the lower limit
  assign divNum = cmd.divSel ? NUM_W'(bandToMhz(bandReg) * REF_MULT)
                             : NUM_W'(baseConst) * NUM_W'(freqReg);
  assign divDen = cmd.divSel ? {1'b0, targetReg} : DEN_W'(SCALE_DIV);

  tuner_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) divI (
    .clk(clk), .rstN(rstN), .go(cmd.divGo),
    .numer(divNum), .denom(divDen), .quot(divQuot), .fin(divDone)
  );

  always_comb begin
    if (divQuot < NUM_W'(BAND1_MIN))      bandNext = 2'd0;
    else if (divQuot < NUM_W'(BAND2_MIN)) bandNext = 2'd1;
    else if (divQuot < NUM_W'(BAND3_MIN)) bandNext = 2'd2;
    else                                  bandNext = 2'd3;
  end

  assign stepAmt  = LIM_W'(tryIdx >> 1);
  assign widenAmt = (bandReg > 2'd1) ? LIM_W'(4) : LIM_W'(2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accSum    <= '0;
      freqReg   <= '0;
      bandReg   <= '0;
      targetReg <= '0;
      lowLim    <= '0;
      highLim   <= '0;
      wordReg   <= '0;
    end else begin
      if (cmd.clrAcc)    accSum  <= '0;
      if (cmd.addSample) accSum  <= accSum + ACC_W'(sampleCnt);
      if (cmd.latchTag)  freqReg <= freqStatus[CNT_W-1:0];
      if (cmd.latchAvg)  freqReg <= accSum[AVG_LOG2 +: CNT_W];
      if (cmd.loadBand) begin
        bandReg   <= bandNext;
        targetReg <= hiSpeedCap ? 7'd66 : 7'd50;
      end
      if (cmd.loadLimits) begin
        lowLim  <= divQuot[LIM_W-1:0];
        highLim <= divQuot[LIM_W-1:0] + widenAmt;
      end
      if (cmd.stepLimits) begin
        if (tryIdx[0]) lowLim  <= lowLim - stepAmt;
        else           highLim <= highLim + stepAmt;
      end
      if (cmd.writeWord)  wordReg <= {highLim, lowLim | LIM_W'(1 << ENABLE_BIT)};
      if (cmd.dropEnable) wordReg[ENABLE_BIT] <= 1'b0;
    end
  end

  assign band      = bandReg;
  assign targetMhz = targetReg;
  assign ctrlWord  = wordReg;
endmodule

// File: rtl/tuner_control.sv
module tuner_control
  import clk_band_tuner_pkg::*;
#(
  parameter int AVG_LOG2     = 7,
  parameter int AVG_WAIT     = 1,
  parameter int POLL_WAIT    = 1,
  parameter int MAX_POLLS    = 20480,
  parameter int HOLD_SAMPLES = 4096,
  parameter int MAX_TRIES    = 8,
  parameter int TRY_W        = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             tagOk,
  input  logic             divDone,
  input  logic             lockFlag,
  output dpCmd_t           cmd,
  output logic [TRY_W-1:0] tryIdx,
  output logic             done,
  output logic             success,
  output logic             fail
);
  localparam int AVG_N  = 1 << AVG_LOG2;
  localparam int WMAX   = (AVG_WAIT > POLL_WAIT) ? AVG_WAIT : POLL_WAIT;
  localparam int WAIT_W = $clog2(WMAX + 1);
  localparam int SAMP_W = AVG_LOG2 + 1;
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam int HOLD_W = $clog2(HOLD_SAMPLES + 1);

  seqState_t         state;
  logic [WAIT_W-1:0] waitCnt;
  logic [SAMP_W-1:0] sampCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic [TRY_W-1:0]  tryCnt;
  logic avgTick, pollTick, holdLast;

  assign avgTick  = (waitCnt == WAIT_W'(AVG_WAIT - 1));
  assign pollTick = (waitCnt == WAIT_W'(POLL_WAIT - 1));
  assign holdLast = (holdCnt == HOLD_W'(HOLD_SAMPLES - 1));
  assign tryIdx   = tryCnt;

  always_comb begin
    cmd = '0;
    case (state)
      S_IDLE:    if (start) begin
                   cmd.latchTag = tagOk;
                   cmd.clrAcc   = !tagOk;
                 end
      S_AVG:     cmd.addSample = avgTick;
      S_AVG_END: cmd.latchAvg = 1'b1;
      S_MHZ_GO:  cmd.divGo = 1'b1;
      S_MHZ_RUN: cmd.loadBand = divDone;
      S_LIM_GO:  begin cmd.divGo = 1'b1; cmd.divSel = 1'b1; end
      S_LIM_RUN: begin cmd.divSel = 1'b1; cmd.loadLimits = divDone; end
      S_WRITE:   cmd.writeWord = 1'b1;
      S_HOLD:    cmd.dropEnable = lockFlag && holdLast;
      S_STEP:    cmd.stepLimits = 1'b1;
      S_REWRITE: cmd.writeWord = 1'b1;
      default:   cmd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      sampCnt <= '0;
      pollCnt <= '0;
      holdCnt <= '0;
      tryCnt  <= '0;
      done    <= 1'b0;
      success <= 1'b0;
      fail    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done    <= 1'b0;
          success <= 1'b0;
          fail    <= 1'b0;
          waitCnt <= '0;
          sampCnt <= '0;
          state   <= tagOk ? S_MHZ_GO : S_AVG;
        end
        S_AVG: if (avgTick) begin
          waitCnt <= '0;
          if (sampCnt == SAMP_W'(AVG_N - 1)) state <= S_AVG_END;
          else sampCnt <= sampCnt + 1'b1;
        end else begin
          waitCnt <= waitCnt + 1'b1;
        end
        S_AVG_END: state <= S_MHZ_GO;
        S_MHZ_GO:  state <= S_MHZ_RUN;
        S_MHZ_RUN: if (divDone) state <= S_LIM_GO;
        S_LIM_GO:  state <= S_LIM_RUN;
        S_LIM_RUN: if (divDone) state <= S_WRITE;
        S_WRITE: begin
          tryCnt  <= '0;
          waitCnt <= '0;
          pollCnt <= '0;
          state   <= S_POLL;
        end
        S_POLL: if (pollTick) begin
          waitCnt <= '0;
          if (lockFlag) begin
            holdCnt <= '0;
            state   <= S_HOLD;
          end else if (pollCnt == POLL_W'(MAX_POLLS - 1)) begin
            state <= S_STEP;
          end else begin
            pollCnt <= pollCnt + 1'b1;
          end
        end else begin
          waitCnt <= waitCnt + 1'b1;
        end
        S_HOLD: if (!lockFlag) begin
          state <= S_STEP;
        end else if (holdLast) begin
          success <= 1'b1;
          done    <= 1'b1;
          state   <= S_IDLE;
        end else begin
          holdCnt <= holdCnt + 1'b1;
        end
        S_STEP: state <= S_REWRITE;
        S_REWRITE: if (tryCnt == TRY_W'(MAX_TRIES - 1)) begin
          fail  <= 1'b1;
          done  <= 1'b1;
          state <= S_IDLE;
        end else begin
          tryCnt  <= tryCnt + 1'b1;
          waitCnt <= '0;
          pollCnt <= '0;
          state   <= S_POLL;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clk_band_tuner.sv
module clk_band_tuner
  import clk_band_tuner_pkg::*;
#(
  parameter int AVG_LOG2     = 7,
  parameter int AVG_WAIT     = 1,
  parameter int POLL_WAIT    = 1,
  parameter int MAX_POLLS    = 20480,
  parameter int HOLD_SAMPLES = 4096,
  parameter int MAX_TRIES    = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] freqStatus,
  input  logic [8:0]  sampleCnt,
  input  logic [7:0]  baseConst,
  input  logic        hiSpeedCap,
  input  logic        lockFlag,
  output logic [1:0]  band,
  output logic [6:0]  targetMhz,
  output logic [31:0] ctrlWord,
  output logic        done,
  output logic        success,
  output logic        fail
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  dpCmd_t           cmd;
  logic [TRY_W-1:0] tryIdx;
  logic             tagOk;
  logic             divDone;

  tuner_control #(
    .AVG_LOG2(AVG_LOG2), .AVG_WAIT(AVG_WAIT), .POLL_WAIT(POLL_WAIT),
    .MAX_POLLS(MAX_POLLS), .HOLD_SAMPLES(HOLD_SAMPLES),
    .MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .start(start), .tagOk(tagOk),
    .divDone(divDone), .lockFlag(lockFlag), .cmd(cmd), .tryIdx(tryIdx),
    .done(done), .success(success), .fail(fail)
  );

  tuner_datapath #(
    .BASE_W(8), .CNT_W(9), .AVG_LOG2(AVG_LOG2), .TRY_W(TRY_W)
  ) dpI (
    .clk(clk), .rstN(rstN), .cmd(cmd), .freqStatus(freqStatus),
    .sampleCnt(sampleCnt), .baseConst(baseConst), .hiSpeedCap(hiSpeedCap),
    .tryIdx(tryIdx), .tagOk(tagOk), .divDone(divDone), .band(band),
    .targetMhz(targetMhz), .ctrlWord(ctrlWord)
  );
endmodule

// File: rtl/clk_band_tuner_chk.sv
module clk_band_tuner_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [1:0]  band,
  input logic [6:0]  targetMhz,
  input logic [31:0] ctrlWord,
  input logic        done,
  input logic        success,
  input logic        fail
);
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(ctrlWord) && $stable(band) && $stable(targetMhz)));

  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> (!done && !success && !fail));

  // R8
  success_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    success |-> (done && !fail && !ctrlWord[8]));

  // R9
  fail_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (done && ctrlWord[8]));

  // R4
  target_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (targetMhz == 7'd50 || targetMhz == 7'd66));

  // R5
  window_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ctrlWord[31:16] > {8'd0, ctrlWord[7:0]}));
endmodule

bind clk_band_tuner clk_band_tuner_chk chkI (.*);

// File: tb/clk_band_tuner_test.sv
module clk_band_tuner_test;
  localparam int CLK_PERIOD = 10;
  localparam int TB_POLLS = 24;
  localparam int TB_HOLD = 16;
  localparam int TB_TRIES = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] freqStatus = '0;
  logic [8:0]  sampleCnt = '0;
  logic [7:0]  baseConst = '0;
  logic        hiSpeedCap = 1'b0;
  logic        lockFlag;
  logic [1:0]  band;
  logic [6:0]  targetMhz;
  logic [31:0] ctrlWord;
  logic        done, success, fail;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int lockMode = 0;
  int lockGoal = 0;
  int sampA = 0, sampB = 0;
  logic sampPhase = 1'b0;
  logic [2:0] glitchCnt = '0;
  int gotQ[$];
  int expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_band_tuner #(
    .AVG_LOG2(7), .AVG_WAIT(1), .POLL_WAIT(3), .MAX_POLLS(TB_POLLS),
    .HOLD_SAMPLES(TB_HOLD), .MAX_TRIES(TB_TRIES)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .freqStatus(freqStatus),
    .sampleCnt(sampleCnt), .baseConst(baseConst), .hiSpeedCap(hiSpeedCap),
    .lockFlag(lockFlag), .band(band), .targetMhz(targetMhz),
    .ctrlWord(ctrlWord), .done(done), .success(success), .fail(fail)
  );

  // DPLL model: lock depends only on the word, or a short periodic glitch
  always_comb begin
    case (lockMode)
      1:       lockFlag = 1'b1;
      2:       lockFlag = (int'(ctrlWord[31:16]) >= lockGoal);
      3:       lockFlag = (int'(ctrlWord[7:0]) <= lockGoal);
      4:       lockFlag = (glitchCnt < 3'd3);
      default: lockFlag = 1'b0;
    endcase
  end

  // Stimulus toggles at the falling edge, away from sampling edges
  always @(negedge clk) begin
    glitchCnt <= glitchCnt + 3'd1;
    sampPhase <= ~sampPhase;
    sampleCnt <= sampPhase ? 9'(sampA) : 9'(sampB);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit modelLock(input int mode, input int w, input int goal);
    case (mode)
      1: return 1'b1;
      2: return ((w >>> 16) & 32'hFFFF) >= goal;
      3: return (w & 255) <= goal;
      default: return 1'b0;
    endcase
  endfunction

  task automatic runCase(input string name, input int status, input int a, input int b,
                         input int base, input int hs, input int mode, input int goal,
                         input int midAfter);
    int freq, mhz, eBand, eTgt, bMhz, low, high, w, last, prevWord;
    bit eSucc;
    bit pulsed;
    int wait_n;
    freqStatus = status; sampA = a; sampB = b; baseConst = 8'(base);
    hiSpeedCap = hs[0]; lockMode = mode; lockGoal = goal;
    prevWord = int'(ctrlWord);
    // expected values from the requirements
    if ((status >>> 12 & 32'hFFFFF) == 32'hABCDE) freq = status & 511;      // R2
    else freq = (((a + b) * 64) / 128) & 511;
    mhz = (base * freq) / 192;                                             // R3
    eBand = (mhz < 40) ? 0 : (mhz < 45) ? 1 : (mhz < 55) ? 2 : 3;
    eTgt = hs ? 66 : 50;                                                   // R4
    bMhz = (eBand == 0) ? 33 : (eBand == 1) ? 40 : (eBand == 2) ? 50 : 66;
    low = (bMhz * 48) / eTgt;                                              // R5
    high = low + 2 + ((eBand > 1) ? 2 : 0);
    expQ.delete(); gotQ.delete();
    last = prevWord; eSucc = 0;
    w = (high << 16) | low | 256;
    if (w != last) begin expQ.push_back(w); last = w; end
    for (int n = 0; n < TB_TRIES; n++) begin
      if (modelLock(mode, w, goal)) begin
        expQ.push_back(w & ~256); eSucc = 1; break;                        // R8
      end
      if (n % 2 == 1) low = low - (n >> 1); else high = high + (n >> 1);   // R7
      w = (high << 16) | low | 256;
      if (w != last) begin expQ.push_back(w); last = w; end
    end
    // run
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done && !success && !fail, "R10", {name, " done/flags clear after start"},
          {done, success, fail}, 0);
    last = prevWord; pulsed = 0; wait_n = 0;
    while (!done && wait_n < 5000) begin
      if (int'(ctrlWord) != last) begin gotQ.push_back(int'(ctrlWord)); last = int'(ctrlWord); end
      if (midAfter != 0 && !pulsed && gotQ.size() == midAfter) begin
        start = 1'b1; pulsed = 1;
      end
      @(negedge clk); start = 1'b0; wait_n++;
    end
    if (int'(ctrlWord) != last) gotQ.push_back(int'(ctrlWord));
    check(done == 1'b1, "R11", {name, " run terminates"}, done, 1);
    check(band == 2'(eBand), "R3", {name, " band"}, band, eBand);
    check(targetMhz == 7'(eTgt), "R4", {name, " target"}, targetMhz, eTgt);
    check(success == eSucc, eSucc ? "R6" : "R9", {name, " success"}, success, eSucc);
    check(fail == !eSucc, "R9", {name, " fail"}, fail, !eSucc);
    check(gotQ.size() == expQ.size(), "R7", {name, " word count"}, gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      check(gotQ[i] == expQ[i], (i == 0) ? "R5" : "R7", {name, " word"}, gotQ[i], expQ[i]);
    // R10: results held while no start arrives
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(done && band == 2'(eBand) && int'(ctrlWord) == expQ[expQ.size()-1],
            "R10", {name, " held"}, ctrlWord, expQ[expQ.size()-1]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R11 watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!done && !success && !fail, "R1", "flags at reset", {done, success, fail}, 0);
    check(ctrlWord == 0 && band == 0 && targetMhz == 0, "R1", "outputs at reset", ctrlWord, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R2 tag path, band1, lock at once (R8)
    runCase("tagged", 32'hABCDE0A0, 7, 9, 48, 1, 1, 0, 0);
    // R2 averaged path with truncation, no lock; mid-run start ignored (R10), fail (R9)
    runCase("averaged", 32'h123450FF, 100, 101, 66, 0, 0, 0, 3);
    // R7 upper widening until lock
    runCase("widen-up", 32'hABCDE0C0, 0, 0, 52, 1, 2, 43, 0);
    // R7 lower widening until lock, band3
    runCase("widen-low", 32'hABCDE0C8, 0, 0, 66, 0, 3, 62, 0);
    // R3 band edges
    runCase("edge39", 32'hABCDE0C0, 0, 0, 39, 0, 1, 0, 0);
    runCase("edge44", 32'hABCDE0C0, 0, 0, 44, 1, 1, 0, 0);
    runCase("edge45", 32'hABCDE0C0, 0, 0, 45, 0, 1, 0, 0);
    runCase("edge54", 32'hABCDE0C0, 0, 0, 54, 1, 1, 0, 0);
    runCase("edge55", 32'hABCDE0C0, 0, 0, 55, 0, 1, 0, 0);
    // R6 short lock pulses never qualify
    runCase("glitch", 32'hABCDE0A0, 0, 0, 48, 0, 4, 0, 0);
    // R2 full-scale average
    runCase("fullscale", 32'h00000000, 511, 511, 255, 1, 1, 0, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule